// File: doc/BRIEF.md
# Single-Cycle Instruction-Fed Integer Core

This block is a 32-bit integer core that retires one instruction on every clock. It has no program counter and does not fetch. Whatever 32-bit word sits on the instruction input during a cycle is decoded, executed and committed at the rising edge that ends that cycle. The supported operations are:

- loading a 20-bit upper immediate,
- a 32-bit add,
- signed and unsigned compare-less-than,
- a word store and a word load.

Operands come from a 32-entry register file whose reads are combinational and whose writes happen on the clock edge. The core also holds a small internal word RAM for data.

Two commit ports make the effect of each instruction visible during its cycle. The register commit port carries the destination register and the value written to it. The store port carries the byte address and the stored word. A surrounding test or trace environment uses these ports to follow the architectural state without reaching into the core.

Top module: `core_top`

## Requirements
- R1: While `rst` is high, `commit_we_o` and `store_en_o` stay low. Synchronous reset clears every register, so an add of two registers right after reset yields 0.
- R2: Major opcode `instr_i[31:29]`=001 writes `{instr_i[24:5], 12'h000}` into register `instr_i[4:0]`.
- R3: Major opcode 000 with function `instr_i[21:15]`=0000010 writes first source (`instr_i[9:5]`) plus second source (`instr_i[14:10]`), modulo 2^32, into register `instr_i[4:0]`.
- R4: Major opcode 000 with function 0000100 writes 1 when the first source is below the second as two's-complement numbers, and 0 otherwise.
- R5: Major opcode 000 with function 0000101 writes 1 when the first source is below the second as unsigned numbers, and 0 otherwise.
- R6: Major opcode 011 stores register `instr_i[4:0]` at address = register `instr_i[9:5]` + sign-extended `instr_i[21:10]`. The store raises `store_en_o` with that address and data, and writes no register.
- R7: Major opcode 010 writes the RAM word at the same address form into register `instr_i[4:0]`. A load in the cycle after a store to that word returns the stored value.
- R8: Register 0 reads as zero and a write to it is dropped, so `commit_we_o` stays low.
- R9: Major opcodes 100 to 111, an unlisted function code, or nonzero `instr_i[28:22]` under opcode 000 cause no register write and no store.
- R10: A value written in one cycle is the source operand seen by the instruction of the next cycle.
- R11: The RAM word is selected by address bits [9:2]. Address bits [1:0] do not affect which word is accessed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction executed in this cycle |
| commit_we_o | output | 1 | A register changes at the end of this cycle |
| commit_rd_o | output | 5 | Register being written |
| commit_data_o | output | 32 | Value being written |
| store_en_o | output | 1 | The RAM is written at the end of this cycle |
| store_addr_o | output | 32 | Byte address of the store |
| store_data_o | output | 32 | Word being stored |

## Verification
The assertions check on every cycle that the core stays quiet in reset and never commits register 0. They also check that a store commits no register and that an illegal major opcode commits nothing. On every cycle they further confirm that compare results are 0 or 1 and that upper-immediate results have clear low bits.

Arithmetic values, sign-extended offsets, write-then-read forwarding across cycles, store-to-load round trips and the misaligned-address aliasing need a running model of the register and RAM contents. Only the bench's instruction scenarios can show these, comparing each commit against that model.

// File: rtl/core_pkg.sv
package core_pkg;

    localparam int XLEN   = 32;
    localparam int RIDX_W = 5;

    localparam logic [2:0] MAJ_ALU = 3'b000;
    localparam logic [2:0] MAJ_LUI = 3'b001;
    localparam logic [2:0] MAJ_LDW = 3'b010;
    localparam logic [2:0] MAJ_STW = 3'b011;

    localparam logic [6:0] FN_ADD  = 7'b0000010;
    localparam logic [6:0] FN_SLT  = 7'b0000100;
    localparam logic [6:0] FN_SLTU = 7'b0000101;

    typedef enum logic [1:0] {
        OP_ADD,
        OP_SLT,
        OP_SLTU,
        OP_PASS_B
    } alu_op_e;

    typedef enum logic {
        IMM_UPPER20,
        IMM_SIGNED12
    } imm_kind_e;

    typedef struct packed {
        logic      reg_we;
        logic      mem_we;
        logic      use_imm;
        logic      from_mem;
        alu_op_e   alu_op;
        imm_kind_e imm_kind;
    } ctrl_t;

    function automatic logic [XLEN-1:0] build_imm(imm_kind_e kind, logic [31:0] w);
        if (kind == IMM_UPPER20) begin
            return {w[24:5], 12'h000};
        end
        return {{(XLEN-12){w[21]}}, w[21:10]};
    endfunction

endpackage

// File: rtl/core_decode.sv
module core_decode
    import core_pkg::*;
(
    input  logic [31:0]       instr_i,
    output ctrl_t             ctrl_o,
    output logic [RIDX_W-1:0] rd_o,
    output logic [RIDX_W-1:0] rj_o,
    output logic [RIDX_W-1:0] rk_o,
    output logic [XLEN-1:0]   imm_o
);
    logic [2:0] major;
    logic [6:0] fn;

    assign major = instr_i[31:29];
    assign fn    = instr_i[21:15];
    assign rd_o  = instr_i[4:0];
    assign rj_o  = instr_i[9:5];
    assign rk_o  = instr_i[14:10];

    always_comb begin
        ctrl_o = '{reg_we: 1'b0, mem_we: 1'b0, use_imm: 1'b0, from_mem: 1'b0,
                   alu_op: OP_ADD, imm_kind: IMM_SIGNED12};
        unique case (major)
            MAJ_ALU: begin
                if (instr_i[28:22] == 7'd0) begin
                    unique case (fn)
                        FN_ADD:  begin ctrl_o.reg_we = 1'b1; ctrl_o.alu_op = OP_ADD;  end
                        FN_SLT:  begin ctrl_o.reg_we = 1'b1; ctrl_o.alu_op = OP_SLT;  end
                        FN_SLTU: begin ctrl_o.reg_we = 1'b1; ctrl_o.alu_op = OP_SLTU; end
                        default: ;
                    endcase
                end
            end
            MAJ_LUI: begin
                ctrl_o.reg_we   = 1'b1;
                ctrl_o.use_imm  = 1'b1;
                ctrl_o.alu_op   = OP_PASS_B;
                ctrl_o.imm_kind = IMM_UPPER20;
            end
            MAJ_LDW: begin
                ctrl_o.reg_we   = 1'b1;
                ctrl_o.use_imm  = 1'b1;
                ctrl_o.from_mem = 1'b1;
            end
            MAJ_STW: begin
                ctrl_o.mem_we  = 1'b1;
                ctrl_o.use_imm = 1'b1;
            end
            default: ;
        endcase
    end

    assign imm_o = build_imm(ctrl_o.imm_kind, instr_i);
endmodule

// File: rtl/core_regfile.sv
module core_regfile
    import core_pkg::*;
#(
    parameter int NREGS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RIDX_W-1:0] ra_a_i,
    input  logic [RIDX_W-1:0] ra_b_i,
    output logic [XLEN-1:0]   rd_a_o,
    output logic [XLEN-1:0]   rd_b_o,
    input  logic              we_i,
    input  logic [RIDX_W-1:0] wa_i,
    input  logic [XLEN-1:0]   wd_i
);
    logic [XLEN-1:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we_i && wa_i != '0) begin
            regs[wa_i] <= wd_i;
        end
    end

    assign rd_a_o = (ra_a_i == '0) ? '0 : regs[ra_a_i];
    assign rd_b_o = (ra_b_i == '0) ? '0 : regs[ra_b_i];
endmodule

// File: rtl/core_alu.sv
module core_alu
    import core_pkg::*;
(
    input  alu_op_e         op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic [XLEN-1:0] y_o
);
    always_comb begin
        unique case (op_i)
            OP_ADD:    y_o = a_i + b_i;
            OP_SLT:    y_o = {{(XLEN-1){1'b0}}, $signed(a_i) < $signed(b_i)};
            OP_SLTU:   y_o = {{(XLEN-1){1'b0}}, a_i < b_i};
            OP_PASS_B: y_o = b_i;
            default:   y_o = '0;
        endcase
    end
endmodule

// File: rtl/core_dram.sv
module core_dram
    import core_pkg::*;
#(
    parameter int WORDS = 256,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [XLEN-1:0]  wd_i,
    output logic [XLEN-1:0]  rd_o
);
    logic [XLEN-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we_i) mem[idx_i] <= wd_i;
    end

    assign rd_o = mem[idx_i];
endmodule

// File: rtl/core_top.sv
module core_top
    import core_pkg::*;
#(
    parameter int DMEM_WORDS = 256,
    localparam int IDX_W = $clog2(DMEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       instr_i,
    output logic              commit_we_o,
    output logic [RIDX_W-1:0] commit_rd_o,
    output logic [XLEN-1:0]   commit_data_o,
    output logic              store_en_o,
    output logic [XLEN-1:0]   store_addr_o,
    output logic [XLEN-1:0]   store_data_o
);
    ctrl_t             ctrl;
    logic [RIDX_W-1:0] rd, rj, rk, rb_sel;
    logic [XLEN-1:0]   imm, src_a, src_b, alu_b, alu_y, mem_q, wb_val;
    logic              do_reg_wr, do_mem_wr;

    core_decode u_dec (
        .instr_i (instr_i),
        .ctrl_o  (ctrl),
        .rd_o    (rd),
        .rj_o    (rj),
        .rk_o    (rk),
        .imm_o   (imm)
    );

    // A store reads its data register through the second port.
    assign rb_sel = ctrl.mem_we ? rd : rk;

    core_regfile #(.NREGS(1 << RIDX_W)) u_rf (
        .clk    (clk),
        .rst    (rst),
        .ra_a_i (rj),
        .ra_b_i (rb_sel),
        .rd_a_o (src_a),
        .rd_b_o (src_b),
        .we_i   (do_reg_wr),
        .wa_i   (rd),
        .wd_i   (wb_val)
    );

    assign alu_b = ctrl.use_imm ? imm : src_b;

    core_alu u_alu (
        .op_i (ctrl.alu_op),
        .a_i  (src_a),
        .b_i  (alu_b),
        .y_o  (alu_y)
    );

    core_dram #(.WORDS(DMEM_WORDS)) u_ram (
        .clk   (clk),
        .we_i  (do_mem_wr),
        .idx_i (alu_y[IDX_W+1:2]),
        .wd_i  (src_b),
        .rd_o  (mem_q)
    );

    assign wb_val    = ctrl.from_mem ? mem_q : alu_y;
    assign do_reg_wr = ctrl.reg_we && !rst;
    assign do_mem_wr = ctrl.mem_we && !rst;

    assign commit_we_o   = do_reg_wr && (rd != '0);
    assign commit_rd_o   = rd;
    assign commit_data_o = wb_val;
    assign store_en_o    = do_mem_wr;
    assign store_addr_o  = alu_y;
    assign store_data_o  = src_b;
endmodule

// File: rtl/core_top_chk.sv
module core_top_chk
    import core_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [31:0]       instr_i,
    input logic              commit_we_o,
    input logic [RIDX_W-1:0] commit_rd_o,
    input logic [XLEN-1:0]   commit_data_o,
    input logic              store_en_o
);
    // R1: no architectural effect while reset is held
    always @(posedge clk) begin
        if (rst) begin
            a_r1_quiet_in_reset: assert (!commit_we_o && !store_en_o)
                else $error("commit during reset");
        end
    end

    // R2: upper immediate leaves the low twelve bits clear
    a_r2_upper_low_clear: assert property (@(posedge clk) disable iff (rst)
        (commit_we_o && instr_i[31:29] == MAJ_LUI) |-> commit_data_o[11:0] == 12'h000);

    // R4: signed compare yields a boolean
    a_r4_slt_boolean: assert property (@(posedge clk) disable iff (rst)
        (commit_we_o && instr_i[31:29] == MAJ_ALU && instr_i[21:15] == FN_SLT)
        |-> commit_data_o[XLEN-1:1] == '0);

    // R5: unsigned compare yields a boolean
    a_r5_sltu_boolean: assert property (@(posedge clk) disable iff (rst)
        (commit_we_o && instr_i[31:29] == MAJ_ALU && instr_i[21:15] == FN_SLTU)
        |-> commit_data_o[XLEN-1:1] == '0);

    // R6: a store commits no register
    a_r6_store_no_reg: assert property (@(posedge clk) disable iff (rst)
        store_en_o |-> !commit_we_o);

    // R8: register 0 is never reported as written
    a_r8_zero_reg_kept: assert property (@(posedge clk) disable iff (rst)
        commit_we_o |-> commit_rd_o != '0);

    // R9: illegal major opcodes do nothing
    a_r9_bad_major_idle: assert property (@(posedge clk) disable iff (rst)
        instr_i[31] |-> (!commit_we_o && !store_en_o));
endmodule

bind core_top core_top_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .instr_i       (instr_i),
    .commit_we_o   (commit_we_o),
    .commit_rd_o   (commit_rd_o),
    .commit_data_o (commit_data_o),
    .store_en_o    (store_en_o)
);

// File: tb/test_core_top.sv
`timescale 1ns / 1ps
module test_core_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] instr;
    logic        c_we;
    logic [4:0]  c_rd;
    logic [31:0] c_data;
    logic        s_en;
    logic [31:0] s_addr;
    logic [31:0] s_data;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2.5 clk = ~clk;

    core_top i_core_top (
        .clk           (clk),
        .rst           (rst),
        .instr_i       (instr),
        .commit_we_o   (c_we),
        .commit_rd_o   (c_rd),
        .commit_data_o (c_data),
        .store_en_o    (s_en),
        .store_addr_o  (s_addr),
        .store_data_o  (s_data)
    );

    typedef struct {
        logic        we;
        logic [4:0]  rd;
        logic [31:0] data;
        logic        st;
        logic [31:0] sa;
        logic [31:0] sd;
        string       req;
    } exp_t;

    exp_t        q[$];
    logic [31:0] m_reg [32];
    logic [31:0] m_mem [int];

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_alu(logic [6:0] fn, int rk, int rj, int rd);
        return {3'b000, 7'b0, fn, rk[4:0], rj[4:0], rd[4:0]};
    endfunction
    function automatic logic [31:0] enc_lui(logic [19:0] imm, int rd);
        return {3'b001, 4'b0, imm, rd[4:0]};
    endfunction
    function automatic logic [31:0] enc_mem(logic [2:0] op, logic [11:0] off, int rj, int rd);
        return {op, 7'b0, off, rj[4:0], rd[4:0]};
    endfunction

    // Reference model built from the requirement text.
    task automatic issue(logic [31:0] w, string req);
        exp_t        e;
        logic [31:0] a, b, d, addr;
        int          rd, rj, rk;
        rd = int'(w[4:0]); rj = int'(w[9:5]); rk = int'(w[14:10]);
        a = m_reg[rj]; b = m_reg[rk]; d = m_reg[rd];
        addr = a + {{20{w[21]}}, w[21:10]};
        e = '{we: 1'b0, rd: w[4:0], data: 32'h0, st: 1'b0, sa: 32'h0, sd: 32'h0, req: req};
        case (w[31:29])
            3'b000: if (w[28:22] == 7'd0) begin
                if (w[21:15] == 7'b0000010) begin e.we = 1'b1; e.data = a + b; end
                else if (w[21:15] == 7'b0000100) begin e.we = 1'b1; e.data = {31'd0, $signed(a) < $signed(b)}; end
                else if (w[21:15] == 7'b0000101) begin e.we = 1'b1; e.data = {31'd0, a < b}; end
            end
            3'b001: begin e.we = 1'b1; e.data = {w[24:5], 12'h000}; end
            3'b010: begin e.we = 1'b1; e.data = m_mem.exists(int'(addr[9:2])) ? m_mem[int'(addr[9:2])] : 32'hx; end
            3'b011: begin e.st = 1'b1; e.sa = addr; e.sd = d; end
            default: ;
        endcase
        if (rd == 0) e.we = 1'b0;
        @(posedge clk);
        #1 instr = w;
        q.push_back(e);
        if (e.we) m_reg[rd] = e.data;
        if (e.st) m_mem[int'(addr[9:2])] = d;
    endtask

    // Monitor: compare each cycle's commit against the oldest expectation.
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.req, "commit_we", {31'd0, c_we}, {31'd0, e.we});
                if (e.we) begin
                    check(e.req, "commit_rd", {27'd0, c_rd}, {27'd0, e.rd});
                    check(e.req, "commit_data", c_data, e.data);
                end
                check(e.req, "store_en", {31'd0, s_en}, {31'd0, e.st});
                if (e.st) begin
                    check(e.req, "store_addr", s_addr, e.sa);
                    check(e.req, "store_data", s_data, e.sd);
                end
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog actual=%0d expected<20000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) m_reg[i] = 32'h0;
        rst = 1'b1;
        instr = enc_alu(7'b0000010, 2, 1, 3);
        repeat (2) @(negedge clk);
        check("R1", "commit_we in reset", {31'd0, c_we}, 32'd0);
        instr = enc_mem(3'b011, 12'd4, 0, 1);
        @(negedge clk);
        check("R1", "store_en in reset", {31'd0, s_en}, 32'd0);
        @(posedge clk);
        #1 rst = 1'b0;

        issue(enc_alu(7'b0000010, 2, 1, 3), "R1");     // regs cleared: 0+0
        issue(enc_lui(20'h12345, 1), "R2");
        issue(enc_lui(20'hABCDE, 2), "R2");
        issue(enc_alu(7'b0000010, 2, 1, 3), "R3_R10"); // 0xBE023000
        issue(enc_alu(7'b0000100, 2, 1, 4), "R4");     // 0
        issue(enc_alu(7'b0000101, 2, 1, 5), "R5");     // 1
        issue(enc_alu(7'b0000100, 1, 2, 6), "R4");     // 1
        issue(enc_alu(7'b0000101, 1, 2, 7), "R5");     // 0
        issue(enc_mem(3'b011, 12'd100, 2, 1), "R6");
        issue(enc_mem(3'b010, 12'd100, 2, 3), "R7");   // 0x12345000
        issue(enc_lui(20'hFFFFF, 0), "R8");
        issue(enc_alu(7'b0000010, 1, 0, 8), "R8");     // 0 + r1
        issue({3'b101, 24'h0, 5'd9}, "R9");
        issue(enc_alu(7'b0000111, 2, 1, 9), "R9");
        issue({3'b000, 7'b0000001, 7'b0000010, 5'd2, 5'd1, 5'd9}, "R9");
        issue(enc_alu(7'b0000010, 9, 0, 10), "R9");    // r9 still 0
        issue(enc_lui(20'h00001, 9), "R2");
        issue(enc_mem(3'b011, 12'hFFC, 9, 5), "R6");   // negative offset
        issue(enc_mem(3'b010, 12'hFFC, 9, 10), "R7");
        issue(enc_mem(3'b011, 12'h013, 9, 3), "R11");  // misaligned store
        issue(enc_mem(3'b010, 12'h010, 9, 11), "R11");
        issue(enc_alu(7'b0000010, 11, 10, 12), "R10");

        @(posedge clk);
        #1 instr = {3'b111, 29'h0};
        while (q.size() > 0) @(posedge clk);
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule